// File: doc/BRIEF.md
# Byte-Lane Simple Dual-Port Block Memory

This block models a simple dual-port memory. One side only writes and the other only reads. The write side always carries an 18-bit word made of two 9-bit lanes. Each lane has its own enable bit, so one half of a stored word can change while the other half stays as it was. The read side has a fixed width, set by parameter to 1, 2, 4, 9 or 18 bits. Its output is registered, and it has its own clock, clock enable and an output-clearing reset. The reset is either synchronous or asynchronous, also set by parameter.

Both sides take a 13-bit address counted in units of the narrowest access. The upper nine bits select one of 512 stored 18-bit words. The write side ignores the four low address bits. On the read side those four bits pick the returned slice of the word. Bit 3 picks the lane, lower lane first. Bits 2 to 0 give the offset inside the lane, aligned to the read width. The memory can start with preset contents, supplied as one flat parameter of 18-bit words.

Top module: `sdp_bytelane_ram`

## Requirements
- R1: A write takes place on a rising edge of `wclk` only when `wce` is high. It targets the word at `waddr[12:4]`; `waddr[3:0]` has no effect on which word is written.
- R2: `wbe[0]` enables word bits [8:0] (taken from `wdata[8:0]`) and `wbe[1]` enables bits [17:9] (taken from `wdata[17:9]`); a lane whose enable is low keeps its stored value, and `wbe` = 00 changes nothing.
- R3: With an 18-bit read width, on a rising edge of `rclk` with `rce` high and `rrst` low, `rdata` takes the full word at `raddr[12:4]` and presents it after that edge.
- R4: With a 9-bit read width, `raddr[3]` = 0 returns word bits [8:0] and `raddr[3]` = 1 returns bits [17:9].
- R5: With a read width W of 1, 2 or 4, the returned bits are W bits starting at word bit (9 x `raddr[3]`) + (`raddr[2:0]` with its low log2(W) bits cleared), least significant bit first; bit 8 of a lane is reachable only at widths 9 and 18.
- R6: When `rce` is low and `rrst` is low, a rising edge of `rclk` leaves `rdata` unchanged whatever `raddr` is.
- R7: In synchronous reset mode, `rrst` high at a rising edge of `rclk` clears `rdata` to zero even when `rce` is low, and does not clear it before that edge.
- R8: In asynchronous reset mode, `rdata` becomes zero as soon as `rrst` rises, without waiting for a clock edge.
- R9: `rdata` is zero before any clock edge.
- R10: Stored word i starts as `INIT[18*i +: 18]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, rising edge |
| wce | input | 1 | Write-side clock enable |
| wbe | input | 2 | Lane write enables, bit 0 low lane, bit 1 high lane |
| waddr | input | ADDR_W (13) | Write address; word index in bits [12:4] |
| wdata | input | 18 | Write data word |
| rclk | input | 1 | Read-side clock, rising edge |
| rce | input | 1 | Read-side clock enable |
| rrst | input | 1 | Read output reset, active high, clears `rdata` |
| raddr | input | ADDR_W (13) | Read address; word in [12:4], slice in [3:0] |
| rdata | output | RD_WIDTH | Registered read data |

## Verification
The hardest case to reach from the ports is a half-word write that lands on a word already holding different data in both lanes, with the untouched lane then read back through every narrow slice width. The stimulus table first fills a word completely, then rewrites one lane at a time with patterns that differ from the old contents, with nonzero low write-address bits. Four copies of the memory, with read widths 18, 9, 4 and 1, share one address and data bus. Every read in the table therefore checks the same stored word through all the slicing rules at once. One copy uses the asynchronous reset, so a reset raised between clock edges can be seen to clear that copy at once while the synchronous copies keep their data until the next edge.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  localparam int SUB_W  = 4;

  // Replace the enabled lanes of a stored word with new data.
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] stored,
    input logic [WORD_W-1:0] incoming,
    input logic [LANES-1:0]  en
  );
    logic [WORD_W-1:0] res;
    res = stored;
    for (int l = 0; l < LANES; l++) begin
      if (en[l]) res[l*LANE_W +: LANE_W] = incoming[l*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // Pick the slice of a word that a read of the given width returns.
  function automatic logic [WORD_W-1:0] read_slice(
    input logic [WORD_W-1:0] word,
    input logic [SUB_W-1:0]  sub,
    input int                width
  );
    logic [LANE_W-1:0] lane_bits;
    logic [2:0]        off;
    logic [WORD_W-1:0] mask;
    if (width >= WORD_W) return word;
    lane_bits = sub[3] ? word[WORD_W-1:LANE_W] : word[LANE_W-1:0];
    if (width == LANE_W) return WORD_W'(lane_bits);
    off  = sub[2:0] & ~3'(width - 1);
    mask = (WORD_W'(1) << width) - WORD_W'(1);
    return WORD_W'(lane_bits >> off) & mask;
  endfunction

endpackage

// File: rtl/sdp_lane_merge.sv
module sdp_lane_merge
  import sdp_pkg::*;
(
  input  logic [WORD_W-1:0] stored,
  input  logic [WORD_W-1:0] incoming,
  input  logic [LANES-1:0]  en,
  output logic [WORD_W-1:0] merged
);

  assign merged = lane_merge(stored, incoming, en);

endmodule

// File: rtl/sdp_read_slicer.sv
module sdp_read_slicer
  import sdp_pkg::*;
#(
  parameter int RD_WIDTH = 18
) (
  input  logic [WORD_W-1:0]   word,
  input  logic [SUB_W-1:0]    sub,
  output logic [RD_WIDTH-1:0] slice
);

  logic [WORD_W-1:0] full;

  assign full  = read_slice(word, sub, RD_WIDTH);
  assign slice = full[RD_WIDTH-1:0];

endmodule

// File: rtl/sdp_read_reg.sv
module sdp_read_reg #(
  parameter int W         = 18,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r = '0;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/sdp_bytelane_ram.sv
module sdp_bytelane_ram
  import sdp_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int RD_WIDTH  = 18,
  parameter bit ASYNC_RST = 1'b0,
  parameter logic [(2**(ADDR_W-4))*18-1:0] INIT = '0
) (
  input  logic                wclk,
  input  logic                wce,
  input  logic [1:0]          wbe,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [17:0]         wdata,
  input  logic                rclk,
  input  logic                rce,
  input  logic                rrst,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [RD_WIDTH-1:0] rdata
);

  localparam int WORD_AW = ADDR_W - SUB_W;
  localparam int WORDS   = 1 << WORD_AW;

  logic [WORD_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = INIT[i*WORD_W +: WORD_W];
  end

  // Named events for the checker.
  logic [WORD_AW-1:0]  wr_idx;
  logic [WORD_AW-1:0]  rd_idx;
  logic [LANES-1:0]    lane_wr;
  logic [WORD_W-1:0]   word_old;
  logic [WORD_W-1:0]   word_new;
  logic [WORD_W-1:0]   rd_word;
  logic [RD_WIDTH-1:0] slice_out;

  assign wr_idx   = waddr[ADDR_W-1:SUB_W];
  assign rd_idx   = raddr[ADDR_W-1:SUB_W];
  assign lane_wr  = {LANES{wce}} & wbe;
  assign word_old = mem[wr_idx];
  assign rd_word  = mem[rd_idx];

  sdp_lane_merge u_merge (
    .stored   (word_old),
    .incoming (wdata),
    .en       (lane_wr),
    .merged   (word_new)
  );

  always_ff @(posedge wclk) begin
    if (|lane_wr) mem[wr_idx] <= word_new;
  end

  sdp_read_slicer #(.RD_WIDTH(RD_WIDTH)) u_slicer (
    .word  (rd_word),
    .sub   (raddr[SUB_W-1:0]),
    .slice (slice_out)
  );

  sdp_read_reg #(.W(RD_WIDTH), .ASYNC_RST(ASYNC_RST)) u_rdreg (
    .clk (rclk),
    .ce  (rce),
    .rst (rrst),
    .d   (slice_out),
    .q   (rdata)
  );

endmodule

// File: rtl/sdp_bytelane_ram_chk.sv
module sdp_bytelane_ram_chk #(
  parameter int ADDR_W   = 13,
  parameter int RD_WIDTH = 18
) (
  input logic                wclk,
  input logic                rclk,
  input logic                rrst,
  input logic                wce,
  input logic [1:0]          wbe,
  input logic [ADDR_W-1:0]   waddr,
  input logic [17:0]         wdata,
  input logic                rce,
  input logic [ADDR_W-1:0]   raddr,
  input logic [RD_WIDTH-1:0] rdata,
  input logic [1:0]          lane_wr,
  input logic [17:0]         word_old,
  input logic [17:0]         word_new,
  input logic [RD_WIDTH-1:0] slice_out
);

  // R2: a disabled lane passes the stored bits through
  a_r2_keep_lo: assert property (@(posedge wclk) disable iff (rrst)
    !lane_wr[0] |-> word_new[8:0] == word_old[8:0]);
  a_r2_keep_hi: assert property (@(posedge wclk) disable iff (rrst)
    !lane_wr[1] |-> word_new[17:9] == word_old[17:9]);

  // R2: an enabled lane takes the incoming data
  a_r2_take_lo: assert property (@(posedge wclk) disable iff (rrst)
    (wce && wbe[0]) |-> word_new[8:0] == wdata[8:0]);

  // R3: an enabled read presents the slice seen at the edge
  a_r3_capture: assert property (@(posedge rclk) disable iff (rrst)
    rce |=> rdata == $past(slice_out));

  // R6: no enable, no change
  a_r6_hold: assert property (@(posedge rclk) disable iff (rrst)
    !rce |=> $stable(rdata));

  // R7: after a reset edge the output reads zero
  a_r7_clear: assert property (@(posedge rclk) disable iff (rrst)
    $past(rrst) |-> rdata == '0);

  // R1: address low bits are only observed here, never decoded for writes
  logic unused_ok;
  assign unused_ok = ^{waddr[3:0], raddr[3:0]};

endmodule

bind sdp_bytelane_ram sdp_bytelane_ram_chk #(
  .ADDR_W   (ADDR_W),
  .RD_WIDTH (RD_WIDTH)
) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .rrst      (rrst),
  .wce       (wce),
  .wbe       (wbe),
  .waddr     (waddr),
  .wdata     (wdata),
  .rce       (rce),
  .raddr     (raddr),
  .rdata     (rdata),
  .lane_wr   (lane_wr),
  .word_old  (word_old),
  .word_new  (word_new),
  .slice_out (slice_out)
);

// File: tb/sdp_bytelane_ram_test.sv
`timescale 1ns/100ps
module sdp_bytelane_ram_test;

  localparam logic [9215:0] TINIT =
    (9216'(18'h2A5A5) << 90) | (9216'(18'h1F0F3) << 126);

  // {wbe, waddr, wdata, raddr}
  localparam logic [45:0] VEC [12] = '{
    {2'b11, 13'h0035, 18'h35A69, 13'h0030},  // R1 full write, low addr bits set
    {2'b00, 13'h0030, 18'h00000, 13'h0038},  // R2 no lanes
    {2'b01, 13'h0031, 18'h3FFAA, 13'h0033},  // R2 low lane only
    {2'b10, 13'h003C, 18'h12345, 13'h003B},  // R2 high lane only
    {2'b11, 13'h1FF0, 18'h3FFFF, 13'h1FFF},
    {2'b01, 13'h0002, 18'h00101, 13'h0004},
    {2'b10, 13'h0000, 18'h2AA00, 13'h000C},
    {2'b11, 13'h0C80, 18'h1B2C3, 13'h0C86},
    {2'b10, 13'h0C87, 18'h00000, 13'h0C8A},
    {2'b11, 13'h003F, 18'h0F0F0, 13'h0031},
    {2'b01, 13'h1FF0, 18'h00000, 13'h1FF7},
    {2'b00, 13'h0C80, 18'h3FFFF, 13'h0C82}
  };

  logic        clk = 1'b0;
  logic        wce = 1'b0;
  logic [1:0]  wbe = 2'b00;
  logic [12:0] waddr = '0;
  logic [17:0] wdata = '0;
  logic        rce = 1'b0;
  logic        rrst = 1'b1;
  logic [12:0] raddr = '0;
  logic [17:0] q18;
  logic [8:0]  q9;
  logic [3:0]  q4;
  logic [0:0]  q1;

  int checks = 0;
  int fails  = 0;
  logic [17:0] mdl [512];

  always #2.5 clk = ~clk;

  sdp_bytelane_ram #(.RD_WIDTH(18), .ASYNC_RST(1'b0), .INIT(TINIT)) uut (
    .wclk(clk), .wce(wce), .wbe(wbe), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rce(rce), .rrst(rrst), .raddr(raddr), .rdata(q18));
  sdp_bytelane_ram #(.RD_WIDTH(9), .ASYNC_RST(1'b0), .INIT(TINIT)) u_n9 (
    .wclk(clk), .wce(wce), .wbe(wbe), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rce(rce), .rrst(rrst), .raddr(raddr), .rdata(q9));
  sdp_bytelane_ram #(.RD_WIDTH(4), .ASYNC_RST(1'b1), .INIT(TINIT)) u_n4 (
    .wclk(clk), .wce(wce), .wbe(wbe), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rce(rce), .rrst(rrst), .raddr(raddr), .rdata(q4));
  sdp_bytelane_ram #(.RD_WIDTH(1), .ASYNC_RST(1'b0), .INIT(TINIT)) u_n1 (
    .wclk(clk), .wce(wce), .wbe(wbe), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rce(rce), .rrst(rrst), .raddr(raddr), .rdata(q1));

  // Expected slice: starting bit = lane base plus width-aligned offset.
  function automatic logic [17:0] want(logic [17:0] w, logic [12:0] ra, int width);
    int base;
    if (width == 18) return w;
    base = ra[3] ? 9 : 0;
    if (width != 9) base = base + (int'(ra[2:0]) / width) * width;
    return 18'((w >> base) & ((18'd1 << width) - 18'd1));
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string ctx);
    logic [17:0] w;
    w = mdl[raddr[12:4]];
    chk({"R3 w18 ", ctx}, q18, want(w, raddr, 18));
    chk({"R4 w9 ", ctx}, 18'(q9), want(w, raddr, 9));
    chk({"R5 w4 ", ctx}, 18'(q4), want(w, raddr, 4));
    chk({"R5 w1 ", ctx}, 18'(q1), want(w, raddr, 1));
  endtask

  task automatic do_write(logic c, logic [1:0] be, logic [12:0] wa, logic [17:0] wd);
    @(negedge clk);
    wce = c; wbe = be; waddr = wa; wdata = wd; rce = 1'b0;
    if (c && be[0]) mdl[wa[12:4]][8:0]  = wd[8:0];
    if (c && be[1]) mdl[wa[12:4]][17:9] = wd[17:9];
    @(negedge clk);
    wce = 1'b0;
  endtask

  task automatic do_read(logic [12:0] ra);
    raddr = ra; rce = 1'b1;
    @(negedge clk);
    rce = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] p18;
    logic [8:0]  p9;
    logic [3:0]  p4;
    logic [0:0]  p1;
    for (int i = 0; i < 512; i++) mdl[i] = TINIT[i*18 +: 18];

    #1;
    chk("R9 w18 start", q18, 18'h0);
    chk("R9 w9 start", 18'(q9), 18'h0);
    chk("R9 w1 start", 18'(q1), 18'h0);
    repeat (2) @(negedge clk);
    rrst = 1'b0;

    // R10 preset contents
    do_read(13'h0050);
    chk("R10 word5", q18, 18'h2A5A5);
    chk_all("R10 word5");
    do_read(13'h0078);
    chk("R10 word7 hi lane", 18'(q9), 18'h0F8);
    chk_all("R10 word7");

    for (int v = 0; v < 12; v++) begin
      logic [45:0] e;
      e = VEC[v];
      do_write(1'b1, e[45:44], e[43:31], e[30:13]);
      do_read(e[12:0]);
      chk_all($sformatf("R1 R2 vec %0d", v));
    end

    // R1: write with wce low must not land
    do_write(1'b0, 2'b11, 13'h0035, 18'h00000);
    do_read(13'h0030);
    chk("R1 wce low ignored", q18, 18'h0F0F0);
    chk_all("R1 wce low");

    // R6: hold with rce low
    do_read(13'h0034);
    p18 = q18; p9 = q9; p4 = q4; p1 = q1;
    raddr = 13'h1FF8;
    @(negedge clk);
    chk("R6 w18 hold", q18, p18);
    chk("R6 w9 hold", 18'(q9), 18'(p9));
    chk("R6 w4 hold", 18'(q4), 18'(p4));
    chk("R6 w1 hold", 18'(q1), 18'(p1));

    // R7: synchronous clear with rce low
    raddr = 13'h0034;
    rrst = 1'b1;
    @(negedge clk);
    rrst = 1'b0;
    chk("R7 w18 clear", q18, 18'h0);
    chk("R7 w9 clear", 18'(q9), 18'h0);
    chk("R7 w1 clear", 18'(q1), 18'h0);

    // R8: asynchronous clear between edges
    do_read(13'h0034);
    chk("R8 w4 loaded", 18'(q4), 18'hF);
    #0.5 rrst = 1'b1;
    #0.7;
    chk("R8 w4 cleared without edge", 18'(q4), 18'h0);
    chk("R7 w18 waits for edge", q18, 18'h0F0F0);
    @(negedge clk);
    rrst = 1'b0;
    chk("R7 w18 cleared at edge", q18, 18'h0);

    finish_run();
  end

endmodule